// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with ID Filtering

This block receives asynchronous serial frames that carry an extra flag bit after the data byte. The flag bit marks a frame as either an address (ID) frame or a data frame. A free-running baud enable pulses at sixteen times the bit rate. The receiver uses it to time each bit and samples the line at the middle of the bit. A frame is a low start bit, eight data bits sent least significant bit first, the flag bit, and a high stop bit.

Software can arm a wake-up filter. While the filter is armed, data frames are dropped without any trace. The first ID frame is stored, and it disarms the filter. Software then compares the stored byte with its own ID. On a mismatch it arms the filter again. On a match it leaves the filter off and takes the data frames that follow.

Overrun and framing errors are latched. While either error flag is set, the receiver stays idle until software clears the flag. The synchronised line level is brought out so that a held-low break can be seen after a framing error.

Top module: `mpr_rx`

## Requirements
- R1: A frame is a low start bit, data bits D0..D7 least significant bit first, the flag bit (1 = ID frame, 0 = data frame), and a stop bit. When a good frame is accepted, the byte goes to `rx_byte`, the flag bit goes to `rx_mpb`, and `rx_full` becomes 1.
- R2: A start is confirmed only if the line is still low 8 baud ticks after it was first seen low. If it is high again at that point, the receiver returns to idle and no flag changes.
- R3: While `filt_en` is 1, a frame whose flag bit is 0 is dropped. No flag changes, and `rx_byte` keeps its value, even if the frame's stop bit is 0.
- R4: While `filt_en` is 1, a good frame whose flag bit is 1 is accepted as in R1, and `filt_en` returns to 0 in the same update.
- R5: When a good frame completes while `rx_full` is still 1, `ovr_err` becomes 1. The new byte is dropped, and `rx_byte` and `rx_mpb` keep the earlier frame.
- R6: A frame whose stop bit is sampled as 0 sets `fer_err`. It does not set `rx_full` and does not change `rx_byte`.
- R7: While `ovr_err` or `fer_err` is 1, no frame is received. Reception resumes once both are cleared.
- R8: `rxd_level` shows the line after synchronisation, so a line held low stays visible as 0 after a framing error.
- R9: `rx_irq` is 1 exactly when any of `rx_full`, `ovr_err` or `fer_err` is 1.
- R10: A one-cycle pulse on `full_clr`, `ovr_clr` or `fer_clr` clears the matching flag. A pulse on `filt_arm` sets `filt_en`.
- R11: After reset, every flag is 0, `rx_byte` is 0 and `rxd_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| filt_arm | input | 1 | Pulse: arm the ID filter |
| full_clr | input | 1 | Pulse: clear rx_full |
| ovr_clr | input | 1 | Pulse: clear ovr_err |
| fer_clr | input | 1 | Pulse: clear fer_err |
| rx_byte | output | 8 | Last accepted data byte |
| rx_mpb | output | 1 | Flag bit of the last accepted frame |
| rx_full | output | 1 | Receive data full |
| ovr_err | output | 1 | Overrun error |
| fer_err | output | 1 | Framing error |
| filt_en | output | 1 | ID filter armed |
| rxd_level | output | 1 | Synchronised line level |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume the clear and arm strobes are single-cycle pulses. They also assume at most one frame completes per frame time, which holds because each bit spans 16 baud ticks. The bench makes a baud tick from a divide-by-four counter. It holds every bit on `rxd` for exactly 64 clocks and issues strobes only while the line is idle between frames. Because of this, the design never sees a clear that coincides with a frame completing.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int DATA_W  = 8;
    localparam int OS_RATE = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS
    } rx_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_DROP,
        EV_FRAMING,
        EV_OVERRUN,
        EV_STORE
    } rx_event_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              stop_ok;
    } rx_frame_t;

    // Decide what a completed frame does to the register state.
    function automatic rx_event_e classify(
        input logic done,
        input logic filtering,
        input logic mpb,
        input logic stop_ok,
        input logic full
    );
        if (!done)                 return EV_NONE;
        if (filtering && !mpb)     return EV_DROP;
        if (!stop_ok)              return EV_FRAMING;
        if (full)                  return EV_OVERRUN;
        return EV_STORE;
    endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
    import mpr_pkg::*;
#(
    parameter int OVS = OS_RATE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      enable,
    output logic      done,
    output rx_frame_t frame
);
    localparam int HALF  = OVS / 2;
    localparam int CW    = $clog2(OVS);
    localparam int NBITS = DATA_W + 2;
    localparam int IW    = $clog2(NBITS);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W:0]   shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= rxd ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            if (idx == IW'(NBITS - 1)) begin
                                done          <= 1'b1;
                                frame.data    <= shreg[DATA_W-1:0];
                                frame.mpb     <= shreg[DATA_W];
                                frame.stop_ok <= rxd;
                                state         <= ST_IDLE;
                            end else begin
                                shreg <= {rxd, shreg[DATA_W:1]};
                                idx   <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_regs.sv
module mpr_regs
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              filt_arm,
    input  logic              full_clr,
    input  logic              ovr_clr,
    input  logic              fer_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_mpb,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              fer_err,
    output logic              filt_en,
    output logic              blocked
);
    rx_event_e ev;

    always_comb begin
        ev = classify(done, filt_en, frame.mpb, frame.stop_ok,
                      rx_full && !full_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            rx_mpb  <= 1'b0;
            rx_full <= 1'b0;
            ovr_err <= 1'b0;
            fer_err <= 1'b0;
            filt_en <= 1'b0;
        end else begin
            if (full_clr) rx_full <= 1'b0;
            if (ovr_clr)  ovr_err <= 1'b0;
            if (fer_clr)  fer_err <= 1'b0;
            if (filt_arm) filt_en <= 1'b1;
            case (ev)
                EV_FRAMING: fer_err <= 1'b1;
                EV_OVERRUN: ovr_err <= 1'b1;
                EV_STORE: begin
                    rx_byte <= frame.data;
                    rx_mpb  <= frame.mpb;
                    rx_full <= 1'b1;
                    if (frame.mpb) filt_en <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign blocked = ovr_err | fer_err;
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx
    import mpr_pkg::*;
#(
    parameter int OVS         = OS_RATE,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              filt_arm,
    input  logic              full_clr,
    input  logic              ovr_clr,
    input  logic              fer_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_mpb,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              fer_err,
    output logic              filt_en,
    output logic              rxd_level,
    output logic              rx_irq
);
    logic      rxd_s;
    logic      done;
    logic      blocked;
    rx_frame_t frame;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rxd_s)
    );

    mpr_frame #(.OVS(OVS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .rxd    (rxd_s),
        .enable (!blocked),
        .done   (done),
        .frame  (frame)
    );

    mpr_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .frame    (frame),
        .filt_arm (filt_arm),
        .full_clr (full_clr),
        .ovr_clr  (ovr_clr),
        .fer_clr  (fer_clr),
        .rx_byte  (rx_byte),
        .rx_mpb   (rx_mpb),
        .rx_full  (rx_full),
        .ovr_err  (ovr_err),
        .fer_err  (fer_err),
        .filt_en  (filt_en),
        .blocked  (blocked)
    );

    assign rxd_level = rxd_s;
    assign rx_irq    = rx_full | ovr_err | fer_err;
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_mpb,
    input logic       rx_full,
    input logic       ovr_err,
    input logic       fer_err,
    input logic       filt_en
);
    AST_FILTER_ONLY_ID: assert property (@(posedge clk) disable iff (rst)
        ($past(filt_en) && $rose(rx_full)) |-> rx_mpb);                    // R3

    AST_ID_DISARMS: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_full) && rx_mpb) |-> !filt_en);                          // R4

    AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> rx_full);                                       // R5

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_full) && rx_full) |-> $stable(rx_byte));                 // R5

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((ovr_err || fer_err) && !rx_full) |=> !rx_full);                  // R7
endmodule

bind mpr_rx mpr_rx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_byte (rx_byte),
    .rx_mpb  (rx_mpb),
    .rx_full (rx_full),
    .ovr_err (ovr_err),
    .fer_err (fer_err),
    .filt_en (filt_en)
);

// File: tb/mpr_rx_bench.sv
module mpr_rx_bench;
    localparam int BIT_CLKS = 64;
    localparam int NVEC     = 6;
    // {data byte, flag bit}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'h00, 1'b0}, {8'hFF, 1'b1}, {8'hA5, 1'b0},
        {8'h5A, 1'b1}, {8'h01, 1'b0}, {8'h80, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick;
    logic rxd = 1'b1;
    logic filt_arm = 1'b0, full_clr = 1'b0, ovr_clr = 1'b0, fer_clr = 1'b0;
    logic [7:0] rx_byte;
    logic rx_mpb, rx_full, ovr_err, fer_err, filt_en, rxd_level, rx_irq;
    logic [1:0] tdiv;
    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) tdiv <= '0;
        else     tdiv <= tdiv + 1'b1;
    end
    assign baud_tick = (tdiv == 2'd3);

    mpr_rx u_mpr_rx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .filt_arm(filt_arm), .full_clr(full_clr), .ovr_clr(ovr_clr),
        .fer_clr(fer_clr), .rx_byte(rx_byte), .rx_mpb(rx_mpb),
        .rx_full(rx_full), .ovr_err(ovr_err), .fer_err(fer_err),
        .filt_en(filt_en), .rxd_level(rxd_level), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic m, input logic s);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = m;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = s;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: filt_arm = 1'b1;
            1: full_clr = 1'b1;
            2: ovr_clr  = 1'b1;
            default: fer_clr = 1'b1;
        endcase
        @(negedge clk);
        filt_arm = 1'b0; full_clr = 1'b0; ovr_clr = 1'b0; fer_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        // R11 reset state
        check("R11 rx_full", rx_full, 0);
        check("R11 ovr_err", ovr_err, 0);
        check("R11 fer_err", fer_err, 0);
        check("R11 filt_en", filt_en, 0);
        check("R11 rx_byte", rx_byte, 0);
        check("R11 rxd_level", rxd_level, 1);
        check("R9 irq idle", rx_irq, 0);

        // R1 / R10 vector table
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][8:1], VEC[v][0], 1'b1);
            check("R1 full", rx_full, 1);
            check("R1 byte", rx_byte, VEC[v][8:1]);
            check("R1 flag", rx_mpb, VEC[v][0]);
            check("R9 irq full", rx_irq, 1);
            pulse(1);
            check("R10 full_clr", rx_full, 0);
        end

        // R2 false start
        @(negedge clk) rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (20 * BIT_CLKS) @(negedge clk);
        check("R2 no full", rx_full, 0);
        check("R2 no fer", fer_err, 0);

        // R3 / R4 filter
        pulse(0);
        check("R10 filt_arm", filt_en, 1);
        send_frame(8'h11, 1'b0, 1'b1);
        check("R3 dropped", rx_full, 0);
        check("R3 byte kept", rx_byte, 8'h80);
        send_frame(8'h22, 1'b0, 1'b0);
        check("R3 no fer", fer_err, 0);
        check("R3 still armed", filt_en, 1);
        send_frame(8'h42, 1'b1, 1'b1);
        check("R4 full", rx_full, 1);
        check("R4 byte", rx_byte, 8'h42);
        check("R4 flag", rx_mpb, 1);
        check("R4 disarmed", filt_en, 0);
        pulse(1);
        send_frame(8'h99, 1'b0, 1'b1);
        check("R4 data after id", rx_byte, 8'h99);
        check("R4 data full", rx_full, 1);
        pulse(1);

        // R5 overrun, R7 blocking
        send_frame(8'h3C, 1'b0, 1'b1);
        send_frame(8'hC3, 1'b1, 1'b1);
        check("R5 ovr", ovr_err, 1);
        check("R5 byte kept", rx_byte, 8'h3C);
        check("R5 flag kept", rx_mpb, 0);
        pulse(1);
        send_frame(8'h5F, 1'b0, 1'b1);
        check("R7 blocked by ovr", rx_full, 0);
        check("R9 irq ovr", rx_irq, 1);
        pulse(2);
        check("R10 ovr_clr", ovr_err, 0);
        send_frame(8'h77, 1'b0, 1'b1);
        check("R7 resumed", rx_byte, 8'h77);
        pulse(1);

        // R6 framing
        send_frame(8'h55, 1'b0, 1'b0);
        check("R6 fer", fer_err, 1);
        check("R6 no full", rx_full, 0);
        check("R6 byte kept", rx_byte, 8'h77);
        pulse(3);
        check("R10 fer_clr", fer_err, 0);

        // R8 break, R7 blocked by framing error
        @(negedge clk) rxd = 1'b0;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R8 break fer", fer_err, 1);
        check("R8 level low", rxd_level, 0);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        send_frame(8'h6B, 1'b0, 1'b1);
        check("R7 blocked by fer", rx_full, 0);
        pulse(3);
        send_frame(8'h6B, 1'b0, 1'b1);
        check("R7 after fer clear", rx_byte, 8'h6B);
        check("R7 full after clear", rx_full, 1);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule